// File: doc/BRIEF.md
# Oscillator Loss Guard with Backup Clock Failover

This block supervises the primary oscillator of a chip using a second, free-running backup clock that does not depend on the oscillator input. A small counter in the oscillator domain produces a slow activity tap. That tap is brought into the backup domain and watched there. If the tap stays quiet for a programmable number of backup cycles, the oscillator is treated as lost. The guard then raises a one-cycle interrupt request, sets a status flag and moves the CPU clock over to the backup source.

The switch between the two sources goes through a handshake mux that cannot produce runt pulses. A single mode input selects whether the CPU sees its source directly or halved. Once the clock has moved to the backup source, it stays there until the next hardware reset, even if the oscillator comes back. The guard can be turned off. The off bit is preset at the end of reset from the inverted level of a strap pin, and software may write it later. While the guard is off, the backup branch idles, the CPU keeps running from the oscillator and no loss is ever reported.

Top module: `osc_failover_guard`

## Requirements
- R1: A loss is declared when the oscillator activity tap (bit TAP_BIT of an oscillator edge counter, default 2, so one change every 4 oscillator rising edges) shows no change for WINDOW backup cycles (default 16). A tap that changes at least every 12 backup cycles never causes a loss. After the oscillator stops, the loss is flagged within WINDOW-2 to WINDOW+6 backup cycles.
- R2: Each failover drives `irq_req` high for exactly one backup cycle, in the cycle `fail_flag` rises, and never again until reset.
- R3: `fail_flag` is 0 after reset, rises on failover and stays 1 until the next reset.
- R4: Before failover, `cpu_clk` is the oscillator clock when `presc_mode`=0 and the oscillator divided by 2 when `presc_mode`=1.
- R5: After failover, `cpu_clk` is the backup clock when `presc_mode`=0 and the backup clock divided by 2 when `presc_mode`=1.
- R6: A returning oscillator does not move `cpu_clk` back and raises no further request. Only reset restores the oscillator as the source.
- R7: The two sources never drive `cpu_clk` together, and no high or low phase of `cpu_clk` is shorter than the shortest half period of the active sources.
- R8: At the end of reset, the off bit takes the inverted level of `strap_in`. Holding `strap_in` at 0 during reset turns the guard off.
- R9: While the guard is off, `fail_flag` and `irq_req` stay 0, the backup branch idles and `cpu_clk` follows the oscillator (direct or halved), even if the oscillator stops.
- R10: A one-cycle `sw_wr` pulse loads `sw_off` (1 = off) into the off bit. The write is ignored while `fail_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Primary oscillator clock under supervision |
| bkp_clk | input | 1 | Free-running backup clock; it clocks the detector and the control logic |
| rst | input | 1 | Synchronous active-high hardware reset, held for several cycles of both clocks |
| strap_in | input | 1 | Strap pin sampled during reset; 0 turns the guard off |
| sw_wr | input | 1 | Write strobe for the off bit, synchronous to `bkp_clk` |
| sw_off | input | 1 | Value written to the off bit (1 = guard off) |
| presc_mode | input | 1 | 0 = direct drive, 1 = selected source halved; held stable outside reset |
| cpu_clk | output | 1 | Selected CPU clock |
| irq_req | output | 1 | One-cycle loss request in the backup domain |
| fail_flag | output | 1 | Sticky failover status |

## Verification
The loss result depends on where the last tap change fell before the stop, so it is not due in a fixed cycle. The bench stops the oscillator on a backup falling edge and counts backup cycles until `fail_flag` rises, then checks that the count falls inside the R1 window. It counts `irq_req` by sampling on backup falling edges, both for the total number of pulses and for the length of each pulse. Clock source and divide ratio are checked by counting `cpu_clk` rising edges over a fixed 1120 ns window, with a tolerance of one edge. Each such window starts only after the mux handshake has had several backup cycles to settle following reset or failover. The strap and software settings are applied between backup falling edges and are judged by their effect at the ports tens of cycles later, well past the one-cycle register latency.

// File: rtl/osc_guard_pkg.sv
package osc_guard_pkg;

    // Which source currently feeds the CPU clock mux.
    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_BKP = 1'b1
    } clk_src_e;

    // Loss event state carried out of the detector.
    typedef struct packed {
        logic fail;  // sticky failover
        logic irq;   // one-cycle request
    } loss_evt_t;

    // Counter width able to hold values 0..n.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl (
    input  logic bkp_clk,
    input  logic rst,
    input  logic strap_in,
    input  logic sw_wr,
    input  logic sw_off,
    input  logic fail,
    output logic off_q
);

    always_ff @(posedge bkp_clk) begin
        if (rst) begin
            off_q <= ~strap_in;          // strap low -> guard off
        end else if (sw_wr && !fail) begin
            off_q <= sw_off;             // writes frozen during failover
        end
    end

    // R10: the off bit cannot move while failover is active
    p_off_frozen_r10: assert property (@(posedge bkp_clk) disable iff (rst)
        fail |=> $stable(off_q));

endmodule

// File: rtl/osc_loss_detector.sv
module osc_loss_detector
    import osc_guard_pkg::*;
#(
    parameter int WINDOW      = 16,
    parameter int TAP_BIT     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic      osc_clk,
    input  logic      bkp_clk,
    input  logic      rst,
    input  logic      arm,
    output loss_evt_t evt
);

    localparam int            CW   = cnt_bits(WINDOW);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    // Oscillator domain: slow activity tap, tolerant of fast oscillators.
    logic [TAP_BIT:0] tap_cnt;
    always_ff @(posedge osc_clk) begin
        if (rst) tap_cnt <= '0;
        else     tap_cnt <= tap_cnt + 1'b1;
    end

    // Backup domain: synchroniser plus one history stage for change detection.
    logic [SYNC_STAGES:0] sync_q;
    always_ff @(posedge bkp_clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], tap_cnt[TAP_BIT]};
    end

    logic seen;
    assign seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    logic [CW-1:0] quiet_q;
    loss_evt_t     evt_q;
    logic          trip;

    assign trip = arm && !seen && !evt_q.fail && (quiet_q == LAST);

    always_ff @(posedge bkp_clk) begin
        if (rst) begin
            quiet_q <= '0;
            evt_q   <= '0;
        end else begin
            evt_q.irq <= trip;
            if (trip) evt_q.fail <= 1'b1;
            if (!arm || seen || evt_q.fail) quiet_q <= '0;
            else if (quiet_q != LAST)       quiet_q <= quiet_q + 1'b1;
        end
    end

    assign evt = evt_q;

    // R1: a seen tap change in a cycle keeps a clear flag clear next cycle
    p_seen_blocks_fail_r1: assert property (@(posedge bkp_clk) disable iff (rst)
        (seen && !evt_q.fail) |=> !evt_q.fail);
    // R2: the request is a single-cycle pulse
    p_irq_one_cycle_r2: assert property (@(posedge bkp_clk) disable iff (rst)
        evt_q.irq |=> !evt_q.irq);
    // R2: the request marks the cycle the flag rises
    p_irq_at_rise_r2: assert property (@(posedge bkp_clk) disable iff (rst)
        evt_q.irq |-> (evt_q.fail && !$past(evt_q.fail)));
    // R3: failover is sticky
    p_fail_sticky_r3: assert property (@(posedge bkp_clk) disable iff (rst)
        evt_q.fail |=> evt_q.fail);
    // R9: a disarmed detector never raises the flag
    p_off_no_fail_r9: assert property (@(posedge bkp_clk) disable iff (rst)
        (!arm && !evt_q.fail) |=> !evt_q.fail);

endmodule

// File: rtl/clk_branch.sv
module clk_branch #(
    parameter bit ASYNC_KILL = 1'b0
) (
    input  logic src_clk,
    input  logic rst,
    input  logic halve,
    input  logic idle,
    input  logic req,
    input  logic force_off,
    output logic out_clk,
    output logic en
);

    logic div_q;
    logic branch_src;
    logic req_s;
    logic en_q;

    always_ff @(posedge src_clk) begin
        if (rst || idle) div_q <= 1'b0;
        else             div_q <= ~div_q;
    end

    assign branch_src = idle ? 1'b0 : (halve ? div_q : src_clk);

    // Enable may only change while the branch output is low.
    generate
        if (ASYNC_KILL) begin : g_kill
            // The source may be dead, so release must not need its edges.
            always_ff @(negedge src_clk or posedge force_off) begin
                if (force_off) begin
                    req_s <= 1'b0;
                    en_q  <= 1'b0;
                end else if (rst) begin
                    req_s <= 1'b0;
                    en_q  <= 1'b0;
                end else begin
                    req_s <= req;
                    if (!(halve && div_q)) en_q <= req_s;
                end
            end
        end else begin : g_sync
            always_ff @(negedge src_clk) begin
                if (rst || force_off) begin
                    req_s <= 1'b0;
                    en_q  <= 1'b0;
                end else begin
                    req_s <= req;
                    if (!(halve && div_q)) en_q <= req_s;
                end
            end
        end
    endgenerate

    assign out_clk = branch_src & en_q;
    assign en      = en_q;

endmodule

// File: rtl/osc_failover_guard.sv
module osc_failover_guard
    import osc_guard_pkg::*;
#(
    parameter int WINDOW      = 16,
    parameter int TAP_BIT     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic bkp_clk,
    input  logic rst,
    input  logic strap_in,
    input  logic sw_wr,
    input  logic sw_off,
    input  logic presc_mode,
    output logic cpu_clk,
    output logic irq_req,
    output logic fail_flag
);

    logic      off_q;
    loss_evt_t evt;
    clk_src_e  sel;
    logic      osc_en, bkp_en;
    logic      osc_out, bkp_out;

    guard_ctrl u_ctrl (
        .bkp_clk  (bkp_clk),
        .rst      (rst),
        .strap_in (strap_in),
        .sw_wr    (sw_wr),
        .sw_off   (sw_off),
        .fail     (evt.fail),
        .off_q    (off_q)
    );

    osc_loss_detector #(
        .WINDOW      (WINDOW),
        .TAP_BIT     (TAP_BIT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_det (
        .osc_clk (osc_clk),
        .bkp_clk (bkp_clk),
        .rst     (rst),
        .arm     (!off_q),
        .evt     (evt)
    );

    assign sel = evt.fail ? SRC_BKP : SRC_OSC;

    clk_branch #(.ASYNC_KILL(1'b1)) u_osc_br (
        .src_clk   (osc_clk),
        .rst       (rst),
        .halve     (presc_mode),
        .idle      (1'b0),
        .req       ((sel == SRC_OSC) && !bkp_en),
        .force_off (evt.fail),
        .out_clk   (osc_out),
        .en        (osc_en)
    );

    clk_branch #(.ASYNC_KILL(1'b0)) u_bkp_br (
        .src_clk   (bkp_clk),
        .rst       (rst),
        .halve     (presc_mode),
        .idle      (off_q),
        .req       ((sel == SRC_BKP) && !osc_en),
        .force_off (1'b0),
        .out_clk   (bkp_out),
        .en        (bkp_en)
    );

    assign cpu_clk   = osc_out | bkp_out;
    assign irq_req   = evt.irq;
    assign fail_flag = evt.fail;

    // R7: the two branches are never enabled together
    p_one_source_r7: assert property (@(posedge bkp_clk) disable iff (rst)
        !(osc_en && bkp_en));
    // R9: an idle backup branch is never enabled
    p_off_no_backup_r9: assert property (@(posedge bkp_clk) disable iff (rst)
        off_q |-> !bkp_en);

endmodule

// File: tb/osc_failover_guard_bench.sv
`timescale 1ns/1ps
module osc_failover_guard_bench;

    localparam int WIN = 16;

    logic bkp_clk = 1'b0;
    logic osc_clk = 1'b0;
    logic osc_run = 1'b1;
    int   osc_half = 7;
    logic rst = 1'b1, strap_in = 1'b1, sw_wr = 1'b0, sw_off = 1'b0, presc_mode = 1'b0;
    logic cpu_clk, irq_req, fail_flag;

    int checks = 0, failures = 0;
    int cpu_edges = 0, irq_cnt = 0, irq_run = 0, irq_long = 0;
    bit done = 1'b0, mon_en = 1'b0;
    realtime last_t = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;

    always #10 bkp_clk = ~bkp_clk;   // 50 MHz backup clock
    always begin
        #(osc_half);
        if (osc_run) osc_clk = ~osc_clk;
        else         osc_clk = 1'b0;
    end

    osc_failover_guard u_osc_failover_guard (
        .osc_clk(osc_clk), .bkp_clk(bkp_clk), .rst(rst), .strap_in(strap_in),
        .sw_wr(sw_wr), .sw_off(sw_off), .presc_mode(presc_mode),
        .cpu_clk(cpu_clk), .irq_req(irq_req), .fail_flag(fail_flag)
    );

    always @(posedge cpu_clk) cpu_edges++;

    always @(cpu_clk) begin
        if (mon_en && last_t > 0.0) begin
            if (cpu_clk == 1'b0) begin
                if ($realtime - last_t < min_hi) min_hi = $realtime - last_t;
            end else begin
                if ($realtime - last_t < min_lo) min_lo = $realtime - last_t;
            end
        end
        last_t = $realtime;
    end

    always @(negedge bkp_clk) begin
        if (irq_req) begin
            irq_cnt++;
            irq_run++;
            if (irq_run > 1) irq_long++;
        end else begin
            irq_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge bkp_clk);
    endtask

    task automatic do_reset(input logic strap, input logic mode);
        mon_en = 1'b0;
        osc_run = 1'b1;
        osc_half = 7;
        cycles(2);
        rst = 1'b1;
        cycles(4);
        strap_in = strap;
        presc_mode = mode;
        cycles(6);
        rst = 1'b0;
        cycles(10);
        last_t = 0.0;
        mon_en = 1'b1;
    endtask

    task automatic rate(input int exp, input int tol, input string req);
        int c0;
        c0 = cpu_edges;
        #1120;
        chk((cpu_edges - c0 >= exp - tol) && (cpu_edges - c0 <= exp + tol),
            req, cpu_edges - c0, exp);
    endtask

    task automatic sw_write(input logic v);
        @(negedge bkp_clk);
        sw_off = v;
        sw_wr = 1'b1;
        @(negedge bkp_clk);
        sw_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        int n;

        // R3 reset state, R4 direct oscillator
        do_reset(1'b1, 1'b0);
        chk(fail_flag == 1'b0, "R3 flag after reset", fail_flag, 0);
        chk(irq_req == 1'b0, "R2 no request after reset", irq_req, 0);
        rate(80, 1, "R4 direct oscillator rate");

        // R4 halved oscillator
        do_reset(1'b1, 1'b1);
        rate(40, 1, "R4 halved oscillator rate");

        // R1 boundary: tap changes every 12 cycles -> no loss; every 20 -> loss
        base = irq_cnt;
        osc_half = 30;
        cycles(150);
        chk(fail_flag == 1'b0, "R1 slow but live oscillator", fail_flag, 0);
        osc_half = 50;
        cycles(80);
        chk(fail_flag == 1'b1, "R1 tap too slow", fail_flag, 1);
        chk(irq_cnt - base == 1, "R2 one request", irq_cnt - base, 1);
        cycles(5);
        rate(28, 1, "R5 halved backup rate");

        // R1 latency, R5 direct backup, R6 stickiness, R10 frozen write
        do_reset(1'b1, 1'b0);
        base = irq_cnt;
        @(negedge bkp_clk);
        osc_run = 1'b0;
        n = 0;
        while (!fail_flag && n < 100) begin
            @(negedge bkp_clk);
            n++;
        end
        chk((n >= WIN - 2) && (n <= WIN + 6), "R1 detection latency", n, WIN);
        cycles(8);
        chk(irq_cnt - base == 1, "R2 one request on stop", irq_cnt - base, 1);
        rate(56, 1, "R5 direct backup rate");
        osc_run = 1'b1;
        cycles(200);
        chk(fail_flag == 1'b1, "R3 flag stays set", fail_flag, 1);
        rate(56, 1, "R6 clock stays on backup");
        chk(irq_cnt - base == 1, "R6 no new request", irq_cnt - base, 1);
        sw_write(1'b1);
        cycles(5);
        rate(56, 1, "R10 write ignored during failover");
        chk(fail_flag == 1'b1, "R10 flag kept after write", fail_flag, 1);
        chk(irq_long == 0, "R2 request width", irq_long, 0);

        // R6 reset restores oscillator
        do_reset(1'b1, 1'b0);
        chk(fail_flag == 1'b0, "R6 flag cleared by reset", fail_flag, 0);
        rate(80, 1, "R6 oscillator back after reset");

        // R8 strap low -> off; R9 no report, clock follows dead oscillator
        do_reset(1'b0, 1'b0);
        base = irq_cnt;
        osc_run = 1'b0;
        cycles(100);
        chk(fail_flag == 1'b0, "R8 strap low disables", fail_flag, 0);
        chk(irq_cnt - base == 0, "R9 no request when off", irq_cnt - base, 0);
        rate(0, 0, "R9 clock follows stopped oscillator");
        osc_run = 1'b1;
        cycles(20);
        rate(80, 1, "R9 oscillator direct when off");

        // R10 software enables the guard
        sw_write(1'b0);
        cycles(5);
        osc_run = 1'b0;
        cycles(60);
        chk(fail_flag == 1'b1, "R10 write enables guard", fail_flag, 1);

        // R10 software disables the guard
        do_reset(1'b1, 1'b0);
        sw_write(1'b1);
        base = irq_cnt;
        osc_run = 1'b0;
        cycles(100);
        chk(fail_flag == 1'b0, "R10 write disables guard", fail_flag, 0);
        chk(irq_cnt - base == 0, "R9 no request after write", irq_cnt - base, 0);

        // R9 halved oscillator while off
        do_reset(1'b0, 1'b1);
        rate(40, 1, "R9 halved oscillator when off");

        // R7 pulse widths over the whole run (half periods 7 ns and up)
        chk(min_hi >= 6.9, "R7 shortest high phase", int'(min_hi), 7);
        chk(min_lo >= 6.9, "R7 shortest low phase", int'(min_lo), 7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule